// File: doc/BRIEF.md
# Load-Level Voltage and Frequency Scaling Controller

This block controls the clock and supply settings of a processor core through four load levels. Level 0 is the heaviest load. Each level carries its own small setting record: a divide ratio, a clock source choice, a clock generator choice and a supply voltage code. The records are packed two per 32-bit word. Software programs the four records and a starting level over a simple 32-bit register bus. It then sets the master scaling enable in the mode register.

While scaling is enabled, a hardware load monitor moves the active level through a valid/level input pair. The block turns the active level's record into a clock-enable strobe for the core, one pulse every N cycles. It also drives a voltage code, a clock source select and a generator select. Each of these outputs has its own enable in the mode register.

While the master enable is set, the level words and the load register are read-only. The mode register stays writable, so it must be written last when settings are restored.

Top module: `dvfs_lvl_ctrl`

## Requirements
- R1: After reset, every register reads zero, `cpu_clk_en` is high on every cycle, and `vdd_sel`, `clk_src_sel` and `gen_sel` are zero.
- R2: Registers are at offset 0x18 (levels 0 and 1), 0x1C (levels 2 and 3), 0x24 (mode) and 0x30 (load, active level in bits [1:0]). A read returns the full stored 32-bit word whatever the lock state. A read of any other offset returns zero.
- R3: While mode bit 31 (master) is set, bus writes to 0x18, 0x1C and 0x30 are ignored. While it is clear, a `load_vld` pulse is ignored. While it is set, a `load_vld` pulse copies `load_lvl` into load bits [1:0] on the next edge.
- R4: The mode register accepts every write, so clearing bit 31 makes the other registers writable again.
- R5: Levels 0 and 2 use word bits [31:16] and levels 1 and 3 use bits [15:0]. Within a half, the fields are: divide ratio [15:13], clock source [11], generator select [10:9], voltage code [7:6].
- R6: With mode bits 29 (divide enable) and 31 both set, `cpu_clk_en` pulses once every N cycles, where N is the active level's divide ratio.
- R7: A divide ratio of 0 acts as 1.
- R8: With bit 29 or bit 31 clear, `cpu_clk_en` is high on every cycle.
- R9: A change of the active ratio takes effect only after the next strobe pulse. The interval already under way keeps the old length.
- R10: `vdd_sel` shows the active level's voltage code when bits 30 and 31 are both set. Otherwise it shows level 0's code.
- R11: `clk_src_sel` follows the active level when bits 26 and 31 are set, and `gen_sel` follows it when bits 28 and 31 are set. Otherwise each shows level 0's field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| load_vld | input | 1 | Level update request from the load monitor |
| load_lvl | input | 2 | Requested level |
| cpu_clk_en | output | 1 | Divided clock-enable strobe for the core |
| vdd_sel | output | 2 | Supply voltage code |
| clk_src_sel | output | 1 | Clock source select (1 = generator) |
| gen_sel | output | 2 | Clock generator select |

## Verification
Some behaviours are checked on every cycle:
- The lock on the level words and the load register.
- The mode register taking whatever is written to it.
- The undivided strobe whenever dividing is off.
- The absence of a second pulse right after a pulse when the ratio is two or more.
- The level-0 voltage code held while voltage scaling is off.

Other behaviours only the bench scenarios show. These are the exact pulse spacing for each ratio, the field decode for all four levels, and the rule that a level change made mid-interval leaves the current interval at its old length and shortens only the next one.

// File: rtl/dvfs_lvl_pkg.sv
package dvfs_lvl_pkg;

    localparam int DATA_W = 32;
    localparam int DIV_W  = 3;

    // register offsets
    localparam int OFS_LVL01 = 'h18;
    localparam int OFS_LVL23 = 'h1C;
    localparam int OFS_MODE  = 'h24;
    localparam int OFS_LOAD  = 'h30;

    // mode register bit positions
    localparam int MB_SRC_EN = 26;
    localparam int MB_GEN_EN = 28;
    localparam int MB_DIV_EN = 29;
    localparam int MB_VDD_EN = 30;
    localparam int MB_MASTER = 31;

    typedef struct packed {
        logic [DATA_W-1:0] lvl01;
        logic [DATA_W-1:0] lvl23;
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] load;
    } regs_t;

    typedef struct packed {
        logic [DIV_W-1:0] ratio;
        logic             src;
        logic [1:0]       gen;
        logic [1:0]       vsel;
    } lvl_cfg_t;

    function automatic lvl_cfg_t dec_half(input logic [15:0] h);
        lvl_cfg_t c;
        c.ratio = h[15:13];
        c.src   = h[11];
        c.gen   = h[10:9];
        c.vsel  = h[7:6];
        return c;
    endfunction

endpackage

// File: rtl/dvfs_regfile.sv
module dvfs_regfile
    import dvfs_lvl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LVL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              load_vld,
    input  logic [LVL_W-1:0]  load_lvl,
    output regs_t             regs_o
);

    regs_t regs_d, regs_q;
    logic  locked;

    assign locked = regs_q.mode[MB_MASTER];

    always_comb begin
        regs_d = regs_q;
        if (bus_we) begin
            if (bus_addr == ADDR_W'(OFS_LVL01) && !locked) regs_d.lvl01 = bus_wdata;
            if (bus_addr == ADDR_W'(OFS_LVL23) && !locked) regs_d.lvl23 = bus_wdata;
            if (bus_addr == ADDR_W'(OFS_LOAD)  && !locked) regs_d.load  = bus_wdata;
            if (bus_addr == ADDR_W'(OFS_MODE))             regs_d.mode  = bus_wdata;
        end
        if (locked && load_vld) regs_d.load[LVL_W-1:0] = load_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_LVL01)) bus_rdata = regs_q.lvl01;
        if (bus_addr == ADDR_W'(OFS_LVL23)) bus_rdata = regs_q.lvl23;
        if (bus_addr == ADDR_W'(OFS_MODE))  bus_rdata = regs_q.mode;
        if (bus_addr == ADDR_W'(OFS_LOAD))  bus_rdata = regs_q.load;
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/dvfs_lvl_sel.sv
module dvfs_lvl_sel
    import dvfs_lvl_pkg::*;
#(
    parameter int LVL_N = 4,
    localparam int LVL_W  = $clog2(LVL_N),
    localparam int WORD_N = LVL_N / 2
) (
    input  regs_t            regs,
    output logic [DIV_W-1:0] act_ratio,
    output logic             div_act,
    output logic [1:0]       vdd_sel,
    output logic             clk_src_sel,
    output logic [1:0]       gen_sel
);

    logic [DATA_W-1:0] words [WORD_N];
    lvl_cfg_t          cfg   [LVL_N];
    lvl_cfg_t          act;
    logic [LVL_W-1:0]  lvl;
    logic              master;
    logic              unused_bits;

    assign words[0] = regs.lvl01;
    assign words[1] = regs.lvl23;

    for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
        if (g % 2 == 0) begin : g_upper
            assign cfg[g] = dec_half(words[g/2][31:16]);
        end else begin : g_lower
            assign cfg[g] = dec_half(words[g/2][15:0]);
        end
    end

    assign lvl         = regs.load[LVL_W-1:0];
    assign act         = cfg[lvl];
    assign master      = regs.mode[MB_MASTER];
    assign unused_bits = ^{regs.load[DATA_W-1:LVL_W], regs.mode[27], regs.mode[25:0]};

    always_comb begin
        act_ratio   = act.ratio;
        div_act     = master && regs.mode[MB_DIV_EN];
        vdd_sel     = (master && regs.mode[MB_VDD_EN]) ? act.vsel : cfg[0].vsel;
        clk_src_sel = (master && regs.mode[MB_SRC_EN]) ? act.src  : cfg[0].src;
        gen_sel     = (master && regs.mode[MB_GEN_EN]) ? act.gen  : cfg[0].gen;
    end

endmodule

// File: rtl/dvfs_clk_strobe.sv
module dvfs_clk_strobe
    import dvfs_lvl_pkg::*;
#(
    parameter int CNT_W = DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_act,
    input  logic [DIV_W-1:0] ratio,
    output logic             clk_en
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t              st_d, st_q;
    logic [DIV_W-1:0] eff;

    always_comb begin
        eff    = (ratio == '0) ? DIV_W'(1) : ratio;
        clk_en = (st_q.cnt == '0);
        st_d   = st_q;
        if (!div_act)    st_d.cnt = '0;
        else if (clk_en) st_d.cnt = CNT_W'(eff - DIV_W'(1));
        else             st_d.cnt = st_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/dvfs_lvl_ctrl.sv
module dvfs_lvl_ctrl
    import dvfs_lvl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LVL_N  = 4,
    localparam int LVL_W = $clog2(LVL_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              load_vld,
    input  logic [LVL_W-1:0]  load_lvl,
    output logic              cpu_clk_en,
    output logic [1:0]        vdd_sel,
    output logic              clk_src_sel,
    output logic [1:0]        gen_sel
);

    regs_t            regs_q;
    logic [DIV_W-1:0] act_ratio;
    logic             div_act;

    dvfs_regfile #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .load_vld  (load_vld),
        .load_lvl  (load_lvl),
        .regs_o    (regs_q)
    );

    dvfs_lvl_sel #(.LVL_N(LVL_N)) u_sel (
        .regs        (regs_q),
        .act_ratio   (act_ratio),
        .div_act     (div_act),
        .vdd_sel     (vdd_sel),
        .clk_src_sel (clk_src_sel),
        .gen_sel     (gen_sel)
    );

    dvfs_clk_strobe u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_act (div_act),
        .ratio   (act_ratio),
        .clk_en  (cpu_clk_en)
    );

endmodule

// File: rtl/dvfs_lvl_chk.sv
module dvfs_lvl_chk
    import dvfs_lvl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              load_vld,
    input logic              cpu_clk_en,
    input logic [1:0]        vdd_sel,
    input logic [DIV_W-1:0]  act_ratio,
    input regs_t             regs_q
);

    logic master, div_on, volt_on;
    assign master  = regs_q.mode[MB_MASTER];
    assign div_on  = master && regs_q.mode[MB_DIV_EN];
    assign volt_on = master && regs_q.mode[MB_VDD_EN];

    p_lock_lvl01_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && master && bus_addr == ADDR_W'(OFS_LVL01)) |=> $stable(regs_q.lvl01));

    p_lock_lvl23_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && master && bus_addr == ADDR_W'(OFS_LVL23)) |=> $stable(regs_q.lvl23));

    p_lock_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && master && !load_vld && bus_addr == ADDR_W'(OFS_LOAD)) |=> $stable(regs_q.load));

    p_mode_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_MODE)) |=> (regs_q.mode == $past(bus_wdata)));

    p_undivided_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !div_on |=> cpu_clk_en);

    p_ratio_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_on && cpu_clk_en && act_ratio <= DIV_W'(1)) |=> cpu_clk_en);

    p_no_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (div_on && cpu_clk_en && act_ratio >= DIV_W'(2)) |=> !cpu_clk_en);

    p_vdd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !volt_on |-> (vdd_sel == regs_q.lvl01[23:22]));

endmodule

bind dvfs_lvl_ctrl dvfs_lvl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .load_vld   (load_vld),
    .cpu_clk_en (cpu_clk_en),
    .vdd_sel    (vdd_sel),
    .act_ratio  (act_ratio),
    .regs_q     (regs_q)
);

// File: tb/dvfs_lvl_ctrl_tb_top.sv
module dvfs_lvl_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // R2 readback, R3 lock, R4 unlock through mode register
    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 8'h18, 32'h1234_5678, 32'h1234_5678, 4'd2},
        '{1'b1, 8'h1C, 32'hCAFE_F00D, 32'hCAFE_F00D, 4'd2},
        '{1'b1, 8'h30, 32'h0000_0003, 32'h0000_0003, 4'd2},
        '{1'b0, 8'h20, 32'h0,         32'h0,         4'd2},
        '{1'b1, 8'h24, 32'h8000_0000, 32'h8000_0000, 4'd4},
        '{1'b1, 8'h18, 32'h0,         32'h1234_5678, 4'd3},
        '{1'b1, 8'h30, 32'h0000_0001, 32'h0000_0003, 4'd3},
        '{1'b1, 8'h1C, 32'h0000_0001, 32'hCAFE_F00D, 4'd3},
        '{1'b1, 8'h24, 32'h0,         32'h0,         4'd4},
        '{1'b1, 8'h18, 32'hAAAA_5555, 32'hAAAA_5555, 4'd4},
        '{1'b0, 8'h00, 32'h0,         32'h0,         4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        load_vld = 1'b0;
    logic [1:0]  load_lvl = '0;
    logic        cpu_clk_en;
    logic [1:0]  vdd_sel;
    logic        clk_src_sel;
    logic [1:0]  gen_sel;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dvfs_lvl_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .load_vld    (load_vld),
        .load_lvl    (load_lvl),
        .cpu_clk_en  (cpu_clk_en),
        .vdd_sel     (vdd_sel),
        .clk_src_sel (clk_src_sel),
        .gen_sel     (gen_sel)
    );

    function automatic logic [15:0] mk(input logic [2:0] div, input logic src,
                                       input logic [1:0] gen, input logic [1:0] v);
        return {div, 1'b0, src, gen, 1'b0, v, 6'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; #1;
        d = bus_rdata;
    endtask

    task automatic hw_lvl(input logic [1:0] l);
        @(negedge clk);
        load_vld = 1'b1; load_lvl = l;
        @(posedge clk); #1;
        load_vld = 1'b0;
    endtask

    task automatic gap(output int g);
        @(negedge clk);
        while (!cpu_clk_en) @(negedge clk);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!cpu_clk_en && g < 40);
    endtask

    task automatic chk_outs(input string req, input logic [1:0] v,
                            input logic s, input logic [1:0] gsel);
        @(negedge clk);
        chk({req, " vdd"}, 32'(vdd_sel), 32'(v));
        chk({req, " src"}, 32'(clk_src_sel), 32'(s));
        chk({req, " gen"}, 32'(gen_sel), 32'(gsel));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int g;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h18, r); chk("R1 lvl01", r, 0);
        rd(8'h1C, r); chk("R1 lvl23", r, 0);
        rd(8'h24, r); chk("R1 mode", r, 0);
        rd(8'h30, r); chk("R1 load", r, 0);
        chk_outs("R1", 2'd0, 1'b0, 2'd0);
        gap(g); chk("R1 strobe", g, 1);

        // table walk: R2 R3 R4
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].we) wr(VEC[i].addr, VEC[i].wdata);
            rd(VEC[i].addr, r);
            chk($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].exp);
        end

        // R5 program the four level records, start level 3
        wr(8'h18, {mk(3'd4, 1'b1, 2'd2, 2'd1), mk(3'd2, 1'b0, 2'd1, 2'd2)});
        wr(8'h1C, {mk(3'd0, 1'b1, 2'd3, 2'd3), mk(3'd6, 1'b1, 2'd1, 2'd0)});
        wr(8'h30, 32'd3);

        // enables without master: level 0 fields, undivided (R10 R11 R8)
        wr(8'h24, 32'h7400_0000);
        chk_outs("R10 R11 no-master", 2'd1, 1'b1, 2'd2);
        gap(g); chk("R8 div-en without master", g, 1);

        // master only: still level 0, undivided
        wr(8'h24, 32'h8000_0000);
        chk_outs("R11 master-only", 2'd1, 1'b1, 2'd2);
        gap(g); chk("R8 master without div-en", g, 1);

        // full enable, level 3: ratio 6 (R5 R6 R10 R11)
        wr(8'h24, 32'hF400_0000);
        chk_outs("R5 level3", 2'd0, 1'b1, 2'd1);
        gap(g); chk("R6 ratio6", g, 6);
        gap(g); chk("R6 ratio6 repeat", g, 6);

        // hardware level 1: ratio 2 (R3 R5 R6)
        hw_lvl(2'd1);
        rd(8'h30, r); chk("R3 hw load", r, 1);
        chk_outs("R5 level1", 2'd2, 1'b0, 2'd1);
        gap(g); gap(g); chk("R6 ratio2", g, 2);

        // level 2: ratio 0 acts as 1 (R7)
        hw_lvl(2'd2);
        chk_outs("R5 level2", 2'd3, 1'b1, 2'd3);
        gap(g); gap(g); chk("R7 ratio0", g, 1);

        // level 0: ratio 4, then a change mid-interval (R9)
        hw_lvl(2'd0);
        gap(g); gap(g); chk("R6 ratio4", g, 4);
        @(negedge clk);
        while (!cpu_clk_en) @(negedge clk);
        load_vld = 1'b1; load_lvl = 2'd1;
        @(posedge clk); #1;
        load_vld = 1'b0;
        g = 1;
        @(negedge clk);
        while (!cpu_clk_en && g < 40) begin
            @(negedge clk);
            g++;
        end
        chk("R9 interval keeps old ratio", g, 4);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!cpu_clk_en && g < 40);
        chk("R9 new ratio after pulse", g, 2);

        // divide enable cleared with master on (R8)
        wr(8'h24, 32'hD400_0000);
        gap(g); chk("R8 div-en cleared", g, 1);

        // master off: hardware request ignored (R3)
        wr(8'h24, 32'h0);
        hw_lvl(2'd3);
        rd(8'h30, r); chk("R3 hw ignored unlocked", r, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule